// File: doc/BRIEF.md
# Inter-Processor Command Dispatcher

This block takes a single 64-bit write from software and turns it into a command for one CPU thread. Every write names a command kind, a target CPU and a 6-bit vector. The block checks the write and then raises a one-cycle strobe on the line for the addressed CPU. There are four strobe vectors, one bit per CPU: post an interrupt, reset, idle (stop executing and ignore interrupts), and resume.

A reset command counts only when its vector equals the power-on-reset trap number. Any other vector raises a one-cycle error pulse and causes no reset. A reset that is accepted is followed on the next cycle by a resume strobe to the same CPU, which brings the freshly reset thread back into execution. A write aimed at a CPU number at or above the populated count does nothing at all. The populated count and the power-on-reset vector are parameters. The reset, halt and wake machinery inside the CPUs lies outside this block.

Top module: `ipi_dispatch`

## Requirements
- R1: While reset is active, and once it is released with no write, every strobe vector, the vector output and the error flag are all zero.
- R2: The command kind is taken from data bits 17:16, the target CPU from bits 12:8 and the vector from bits 5:0. No other data bit has any effect.
- R3: Kind 0 (interrupt) to CPU n raises bit n of `irq_strb` for one cycle. That cycle is the cycle after the write edge, and in it `strb_vec` carries the vector.
- R4: Kind 1 (reset) to CPU n with vector equal to `POR_VEC` raises bit n of `rst_strb` for one cycle, with `strb_vec` carrying the vector. On the following cycle it raises bit n of `wake_strb`.
- R5: Kind 1 with any vector other than `POR_VEC` raises no strobe. It pulses `cmd_err` for one cycle instead.
- R6: Kind 2 (idle) to CPU n raises bit n of `idle_strb` for one cycle.
- R7: Kind 3 (resume) to CPU n raises bit n of `wake_strb` for one cycle.
- R8: A write whose target CPU number is greater than or equal to `NUM_CPUS` produces no strobe and no error, whatever its kind and vector.
- R9: In any cycle at most one of `irq_strb`, `rst_strb`, `idle_strb` is nonzero, each has at most one bit set, and `strb_vec` is zero whenever neither `irq_strb` nor `rst_strb` is set.
- R10: With `cmd_wr` low, the data input has no effect.
- R11: Writes on consecutive cycles are each carried out. The resume that follows an accepted reset is merged with the strobes of the next write (ORed into `wake_strb`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_data | input | 64 | Command word |
| irq_strb | output | NUM_CPUS | Interrupt strobe, one bit per CPU |
| rst_strb | output | NUM_CPUS | Reset strobe, one bit per CPU |
| idle_strb | output | NUM_CPUS | Idle strobe, one bit per CPU |
| wake_strb | output | NUM_CPUS | Resume strobe, one bit per CPU |
| strb_vec | output | 6 | Vector accompanying an interrupt or reset strobe |
| cmd_err | output | 1 | One-cycle pulse for a reset with a wrong vector |

## Verification
The bench sends every kind to every populated CPU. It also sends the same words with the unused bit fields filled with ones, so that a decoder that reads a wrong bit position is caught. Targets just past the populated count and at the top of the 5-bit field, combined with every kind and with good and bad reset vectors, separate the range check from the reset vector check. Back-to-back pairs check that the resume following a reset merges with the next write's strobe (same CPU and different CPU). A write strobe held low under live data shows that the data bus alone has no effect.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int DATA_W    = 64;
  localparam int KIND_LSB  = 16;
  localparam int KIND_W    = 2;
  localparam int CPU_LSB   = 8;
  localparam int CPU_FLD_W = 5;
  localparam int VEC_LSB   = 0;
  localparam int VEC_W     = 6;

  typedef enum logic [KIND_W-1:0] {
    K_IRQ   = 2'd0,
    K_RESET = 2'd1,
    K_IDLE  = 2'd2,
    K_WAKE  = 2'd3
  } ipi_kind_e;

  typedef struct packed {
    ipi_kind_e            kind;
    logic [CPU_FLD_W-1:0] cpu;
    logic [VEC_W-1:0]     vec;
  } ipi_req_t;
endpackage

// File: rtl/ipi_rst_sync.sv
module ipi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int              NUM_CPUS = 8,
  parameter logic [VEC_W-1:0] POR_VEC = 6'h01
) (
  input  logic [DATA_W-1:0] data,
  output ipi_req_t          req,
  output logic              in_range,
  output logic              vec_is_por
);
  logic unused_bits;

  always_comb begin
    req.kind   = ipi_kind_e'(data[KIND_LSB +: KIND_W]);
    req.cpu    = data[CPU_LSB +: CPU_FLD_W];
    req.vec    = data[VEC_LSB +: VEC_W];
    in_range   = ({1'b0, req.cpu} < (CPU_FLD_W+1)'(NUM_CPUS));
    vec_is_por = (req.vec == POR_VEC);
  end

  assign unused_bits = ^{data[DATA_W-1:KIND_LSB+KIND_W],
                         data[KIND_LSB-1:CPU_LSB+CPU_FLD_W],
                         data[CPU_LSB-1:VEC_LSB+VEC_W]};
endmodule

// File: rtl/ipi_strobe_gen.sv
module ipi_strobe_gen
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  ipi_req_t            req,
  input  logic                in_range,
  input  logic                vec_is_por,
  output logic [NUM_CPUS-1:0] irq_q,
  output logic [NUM_CPUS-1:0] rst_q,
  output logic [NUM_CPUS-1:0] idle_q,
  output logic [NUM_CPUS-1:0] wake_q,
  output logic [VEC_W-1:0]    vec_q,
  output logic                err_q
);
  logic                fire;
  logic                rst_ok;
  logic [NUM_CPUS-1:0] sel;
  logic [NUM_CPUS-1:0] irq_d, rst_d, idle_d, wake_d;
  logic [VEC_W-1:0]    vec_d;
  logic                err_d;

  always_comb begin
    fire   = wr_en && in_range;
    rst_ok = (req.kind == K_RESET) && vec_is_por;
    err_d  = fire && (req.kind == K_RESET) && !vec_is_por;
    vec_d  = (fire && ((req.kind == K_IRQ) || rst_ok)) ? req.vec : '0;
  end

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_cpu
    always_comb begin
      sel[i]    = fire && (req.cpu == CPU_FLD_W'(i));
      irq_d[i]  = sel[i] && (req.kind == K_IRQ);
      rst_d[i]  = sel[i] && rst_ok;
      idle_d[i] = sel[i] && (req.kind == K_IDLE);
      // a reset accepted last cycle is followed by a resume
      wake_d[i] = (sel[i] && (req.kind == K_WAKE)) || rst_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= '0;
      rst_q  <= '0;
      idle_q <= '0;
      wake_q <= '0;
      vec_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      rst_q  <= rst_d;
      idle_q <= idle_d;
      wake_q <= wake_d;
      vec_q  <= vec_d;
      err_q  <= err_d;
    end
  end

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|irq_q, |rst_q, |idle_q})) else $error("AST_ONE_KIND"); // R9
  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_q) && $onehot0(rst_q) && $onehot0(idle_q)) else $error("AST_IRQ_ONEHOT"); // R9
  AST_WAKE_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (|rst_q) |=> ((wake_q & $past(rst_q)) == $past(rst_q))) else $error("AST_WAKE_AFTER_RST"); // R4
  AST_ERR_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (rst_q == '0)) else $error("AST_ERR_NO_RST"); // R5
  AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_q == '0) && (rst_q == '0)) |-> (vec_q == '0)) else $error("AST_VEC_IDLE_ZERO"); // R9
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int              NUM_CPUS = 8,
  parameter logic [VEC_W-1:0] POR_VEC = 6'h01
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr,
  input  logic [63:0]         cmd_data,
  output logic [NUM_CPUS-1:0] irq_strb,
  output logic [NUM_CPUS-1:0] rst_strb,
  output logic [NUM_CPUS-1:0] idle_strb,
  output logic [NUM_CPUS-1:0] wake_strb,
  output logic [5:0]          strb_vec,
  output logic                cmd_err
);
  logic     srst_n;
  ipi_req_t req;
  logic     in_range;
  logic     vec_is_por;

  ipi_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ipi_decode #(.NUM_CPUS(NUM_CPUS), .POR_VEC(POR_VEC)) u_decode (
    .data       (cmd_data),
    .req        (req),
    .in_range   (in_range),
    .vec_is_por (vec_is_por)
  );

  ipi_strobe_gen #(.NUM_CPUS(NUM_CPUS)) u_strobe (
    .clk        (clk),
    .rst_n      (srst_n),
    .wr_en      (cmd_wr),
    .req        (req),
    .in_range   (in_range),
    .vec_is_por (vec_is_por),
    .irq_q      (irq_strb),
    .rst_q      (rst_strb),
    .idle_q     (idle_strb),
    .wake_q     (wake_strb),
    .vec_q      (strb_vec),
    .err_q      (cmd_err)
  );

  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_wr && (cmd_data[12:8] >= 5'(NUM_CPUS))) |=>
      ((irq_strb == '0) && (rst_strb == '0) && (idle_strb == '0) && !cmd_err))
    else $error("AST_OUT_OF_RANGE"); // R8
  AST_NO_WR_NO_CMD: assert property (@(posedge clk) disable iff (!srst_n)
    !cmd_wr |=> ((irq_strb == '0) && (rst_strb == '0) && (idle_strb == '0) && !cmd_err))
    else $error("AST_NO_WR_NO_CMD"); // R10
  AST_IRQ_VEC: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_wr && (cmd_data[17:16] == 2'd0) && (cmd_data[12:8] < 5'(NUM_CPUS))) |=>
      (strb_vec == $past(cmd_data[5:0])))
    else $error("AST_IRQ_VEC"); // R3
endmodule

// File: tb/ipi_dispatch_tb.sv
module ipi_dispatch_tb_top;
  localparam int NCPU = 8;
  localparam logic [5:0] POR = 6'h01;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cmd_wr;
  logic [63:0]     cmd_data;
  logic [NCPU-1:0] irq_strb, rst_strb, idle_strb, wake_strb;
  logic [5:0]      strb_vec;
  logic            cmd_err;

  always #2.5 clk = ~clk;

  ipi_dispatch #(.NUM_CPUS(NCPU), .POR_VEC(POR)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .irq_strb(irq_strb), .rst_strb(rst_strb), .idle_strb(idle_strb),
    .wake_strb(wake_strb), .strb_vec(strb_vec), .cmd_err(cmd_err)
  );

  typedef struct {
    logic [NCPU-1:0] irq, rst, idle, wake;
    logic [5:0]      vec;
    logic            err;
    string           tag;
  } exp_t;

  exp_t            sb_q[$];
  int              checks = 0;
  int              errors = 0;
  logic [NCPU-1:0] pend_wake = '0;
  bit              done = 0;

  function automatic logic [63:0] mk(int kind, int cpu, int vec);
    return {46'd0, 2'(kind), 3'd0, 5'(cpu), 2'd0, 6'(vec)};
  endfunction

  task automatic compare(exp_t e);
    checks++;
    if (irq_strb !== e.irq || rst_strb !== e.rst || idle_strb !== e.idle ||
        wake_strb !== e.wake || strb_vec !== e.vec || cmd_err !== e.err) begin
      errors++;
      $display("FAIL %s act irq=%h rst=%h idle=%h wake=%h vec=%h err=%b exp irq=%h rst=%h idle=%h wake=%h vec=%h err=%b",
               e.tag, irq_strb, rst_strb, idle_strb, wake_strb, strb_vec, cmd_err,
               e.irq, e.rst, e.idle, e.wake, e.vec, e.err);
    end
  endtask

  // driver: one cycle, with or without a write, pushing the expected result
  task automatic drive(bit wr, logic [63:0] d, string tag);
    exp_t e;
    int kind, cpu, vec;
    bit   ok;
    @(negedge clk);
    cmd_wr   = wr;
    cmd_data = d;
    kind = int'(d[17:16]);
    cpu  = int'(d[12:8]);
    vec  = int'(d[5:0]);
    ok   = wr && (cpu < NCPU);
    e.irq = '0; e.rst = '0; e.idle = '0; e.wake = pend_wake;
    e.vec = '0; e.err = 1'b0; e.tag = tag;
    if (ok) begin
      case (kind)
        0: begin e.irq[cpu] = 1'b1; e.vec = 6'(vec); end
        1: if (6'(vec) == POR) begin e.rst[cpu] = 1'b1; e.vec = 6'(vec); end
           else e.err = 1'b1;
        2: e.idle[cpu] = 1'b1;
        default: e.wake[cpu] = 1'b1;
      endcase
    end
    pend_wake = e.rst;
    sb_q.push_back(e);
  endtask

  task automatic idle_cyc(string tag);
    drive(1'b0, 64'd0, tag);
  endtask

  // monitor: pops and compares shortly after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) compare(sb_q.pop_front());
    end
  end

  initial begin
    #(5ns * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t z;
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_data = '0;
    repeat (3) @(negedge clk);
    z.irq = '0; z.rst = '0; z.idle = '0; z.wake = '0; z.vec = '0; z.err = 1'b0;
    z.tag = "R1 in reset";
    compare(z);
    rst_n = 1'b1;
    repeat (4) idle_cyc("R1 after release");

    // R3 R4 R6 R7 each kind to each CPU
    for (int c = 0; c < NCPU; c++) begin
      drive(1'b1, mk(0, c, 6'h20 + c), "R3 irq");
      drive(1'b1, mk(1, c, POR), "R4 reset");
      idle_cyc("R4 follow-up resume");
      drive(1'b1, mk(2, c, 6'h3f), "R6 idle");
      drive(1'b1, mk(3, c, 6'h15), "R7 resume");
      idle_cyc("R9 strobe one cycle");
    end
    drive(1'b1, mk(0, 5, 6'h3f), "R3 max vec");
    drive(1'b1, mk(0, 5, 6'h00), "R3 zero vec");

    // R2 unused bits set to one
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, mk(k, 3, (k == 1) ? int'(POR) : 6'h2a) |
                  64'hFFFF_FFFF_FFFC_E0C0, "R2 junk bits");
      idle_cyc("R2 gap");
    end

    // R5 bad reset vectors
    drive(1'b1, mk(1, 2, 6'h00), "R5 bad vec 0");
    drive(1'b1, mk(1, 2, 6'h02), "R5 bad vec 2");
    drive(1'b1, mk(1, 7, 6'h3f), "R5 bad vec 3f");
    idle_cyc("R5 pulse one cycle");

    // R8 out of range targets
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, mk(k, NCPU, POR), "R8 cpu=N");
      drive(1'b1, mk(k, 31, 6'h07), "R8 cpu=31");
    end
    drive(1'b1, mk(1, NCPU + 1, 6'h09), "R8 bad vec no err");
    idle_cyc("R8 gap");

    // R10 data without write strobe
    drive(1'b0, mk(0, 1, 6'h11), "R10 irq data no wr");
    drive(1'b0, mk(1, 1, POR), "R10 reset data no wr");
    drive(1'b0, mk(1, 1, 6'h05), "R10 bad reset no wr");

    // R11 back-to-back
    drive(1'b1, mk(1, 1, POR), "R11 reset cpu1");
    drive(1'b1, mk(0, 4, 6'h0c), "R11 irq cpu4 with resume cpu1");
    drive(1'b1, mk(1, 5, POR), "R11 reset cpu5");
    drive(1'b1, mk(3, 5, 6'h00), "R11 resume merged cpu5");
    drive(1'b1, mk(1, 6, POR), "R11 reset cpu6");
    drive(1'b1, mk(1, 0, POR), "R11 reset cpu0 + resume cpu6");
    drive(1'b1, mk(2, 0, 6'h00), "R11 idle cpu0 + resume cpu0");
    idle_cyc("R11 drain");
    idle_cyc("R11 drain");

    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule